// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control of a five-stage in-order pipeline. The stages are fetch, decode with register read, execute, memory access and write-back. The unit is purely combinational. It watches the register numbers and control bits held in the pipeline registers and works out how each dependency is resolved.

- **Forwarding selects.** Two selects steer the execute-stage ALU operand muxes. Two more steer the operand muxes of the equality comparator, because branches resolve early, in decode.
- **Stall.** When forwarding cannot supply a value in time, the unit freezes the PC and the fetch/decode register. It also turns the instruction entering execute into a bubble.
- **Taken branch.** When the branch in decode is taken, the unit redirects the PC and flushes the fetch/decode register in the same cycle.

Instruction and data memories are separate, so a load or store never stalls fetch. The datapath instantiates this unit and feeds it the stage fields. The clock and reset inputs only give the bound property checker a sampling edge; no output depends on them.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: An execute-stage operand select is 2'b10 when the execute/memory stage writes a register, its destination is nonzero, and that destination equals the operand's source register.
- R2: An execute-stage operand select is 2'b01 when only the memory/write-back stage has such a match (it writes a register and its destination is nonzero).
- R3: When both later stages match the same execute-stage source, the execute/memory match wins and the select is 2'b10; each operand is resolved on its own.
- R4: Register 0, or a stage whose register-write bit is clear, is never a forwarding source; the select is then 2'b00, and 2'b11 never appears on any select.
- R5: A load in execute (memory-read bit set) with a nonzero destination raises stall_pc, stall_ifid and bubble_idex together when that destination equals the decode rs, or the decode rt while the decode instruction uses rt; an rt match with rt unused causes no stall.
- R6: A branch in decode whose rs or rt equals the nonzero destination of a register-writing non-load in execute stalls (all three stall outputs high).
- R7: A branch in decode whose rs or rt equals the nonzero destination of a load in the memory stage stalls, so a load directly ahead of a dependent branch costs two stall cycles.
- R8: The decode comparator selects use the same codes: 2'b10 for a non-load execute/memory match, 2'b01 for a memory/write-back match, with execute/memory winning; a load in execute/memory is never a decode forwarding source.
- R9: branch_taken and flush_ifid are high exactly when decode holds a branch, the comparator reports equal, and no stall is raised.
- R10: No stall is raised outside the cases of R5 to R7; a load or store in a later stage never stalls a non-dependent or non-branch instruction by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bound checker |
| rst_n | input | 1 | Active-low reset, disables checking |
| ifid_rs | input | RA_W | Decode instruction first source |
| ifid_rt | input | RA_W | Decode instruction second source |
| ifid_rt_used | input | 1 | Decode instruction reads its second source |
| ifid_branch | input | 1 | Decode instruction is an equality branch |
| ifid_cmp_eq | input | 1 | Decode comparator result (operands equal) |
| idex_rs | input | RA_W | Execute instruction first source |
| idex_rt | input | RA_W | Execute instruction second source |
| idex_rd | input | RA_W | Execute instruction destination |
| idex_regwrite | input | 1 | Execute instruction writes a register |
| idex_memread | input | 1 | Execute instruction is a load |
| exmem_rd | input | RA_W | Memory-stage destination |
| exmem_regwrite | input | 1 | Memory-stage instruction writes a register |
| exmem_memread | input | 1 | Memory-stage instruction is a load |
| memwb_rd | input | RA_W | Write-back destination |
| memwb_regwrite | input | 1 | Write-back instruction writes a register |
| fwd_ex_a | output | 2 | Execute operand A select |
| fwd_ex_b | output | 2 | Execute operand B select |
| fwd_id_a | output | 2 | Decode comparator operand A select |
| fwd_id_b | output | 2 | Decode comparator operand B select |
| stall_pc | output | 1 | Hold the PC |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| bubble_idex | output | 1 | Zero control bits entering execute |
| flush_ifid | output | 1 | Turn fetch/decode contents into a no-op |
| branch_taken | output | 1 | Load the branch target into the PC |

## Verification
The properties assume the stage fields are settled and coherent at each rising edge, and that each set describes one real instruction. A load must carry both its memory-read and register-write bits. Branch fields describe an instruction that reads both sources.

The stimulus changes all fields together on the falling edge. Every vector sets the control bits as a real instruction of that kind would, and the walk-through of a load feeding a branch moves one destination through execute, memory and write-back on successive cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WBACK   = 2'b01,
    SEL_MEMSTG  = 2'b10
  } fwd_sel_e;

  // Newer result has priority over older result.
  function automatic fwd_sel_e fwd_choose(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SEL_MEMSTG;
    else if (wb_hit) return SEL_WBACK;
    else             return SEL_REGFILE;
  endfunction

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int RA_W        = 5,
  parameter bit MEM_LOAD_OK = 1'b1
) (
  input  logic [RA_W-1:0] src_reg,
  input  logic [RA_W-1:0] mem_rd,
  input  logic            mem_wr,
  input  logic            mem_ld,
  input  logic [RA_W-1:0] wb_rd,
  input  logic            wb_wr,
  output logic [1:0]      sel,
  output logic            mem_hit,
  output logic            wb_hit
);

  function automatic logic dst_match(input logic wr, input logic [RA_W-1:0] rd,
                                     input logic [RA_W-1:0] src);
    return wr && (rd != '0) && (rd == src);
  endfunction

  logic mem_usable;
  fwd_sel_e choice;

  // A load's data is not ready in the memory stage for a decode-stage consumer.
  assign mem_usable = MEM_LOAD_OK ? 1'b1 : !mem_ld;
  assign mem_hit    = mem_usable && dst_match(mem_wr, mem_rd, src_reg);
  assign wb_hit     = dst_match(wb_wr, wb_rd, src_reg);
  assign choice     = fwd_choose(mem_hit, wb_hit);
  assign sel        = choice;

endmodule

// File: rtl/hz_stall_det.sv
module hz_stall_det #(
  parameter int RA_W = 5
) (
  input  logic [RA_W-1:0] ifid_rs,
  input  logic [RA_W-1:0] ifid_rt,
  input  logic            ifid_rt_used,
  input  logic            ifid_branch,
  input  logic [RA_W-1:0] idex_rd,
  input  logic            idex_regwrite,
  input  logic            idex_memread,
  input  logic [RA_W-1:0] exmem_rd,
  input  logic            exmem_memread,
  output logic            hit_load_use,
  output logic            hit_br_alu,
  output logic            hit_br_load
);

  function automatic logic reads_dst(input logic [RA_W-1:0] rd, input logic [RA_W-1:0] rs,
                                     input logic [RA_W-1:0] rt, input logic rt_live);
    return (rd != '0) && ((rd == rs) || (rt_live && (rd == rt)));
  endfunction

  logic rt_live;

  // A branch always compares both sources.
  assign rt_live      = ifid_rt_used || ifid_branch;
  assign hit_load_use = idex_memread && reads_dst(idex_rd, ifid_rs, ifid_rt, rt_live);
  assign hit_br_alu   = ifid_branch && idex_regwrite && !idex_memread &&
                        reads_dst(idex_rd, ifid_rs, ifid_rt, 1'b1);
  assign hit_br_load  = ifid_branch && exmem_memread &&
                        reads_dst(exmem_rd, ifid_rs, ifid_rt, 1'b1);

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] ifid_rs,
  input  logic [RA_W-1:0] ifid_rt,
  input  logic            ifid_rt_used,
  input  logic            ifid_branch,
  input  logic            ifid_cmp_eq,
  input  logic [RA_W-1:0] idex_rs,
  input  logic [RA_W-1:0] idex_rt,
  input  logic [RA_W-1:0] idex_rd,
  input  logic            idex_regwrite,
  input  logic            idex_memread,
  input  logic [RA_W-1:0] exmem_rd,
  input  logic            exmem_regwrite,
  input  logic            exmem_memread,
  input  logic [RA_W-1:0] memwb_rd,
  input  logic            memwb_regwrite,
  output logic [1:0]      fwd_ex_a,
  output logic [1:0]      fwd_ex_b,
  output logic [1:0]      fwd_id_a,
  output logic [1:0]      fwd_id_b,
  output logic            stall_pc,
  output logic            stall_ifid,
  output logic            bubble_idex,
  output logic            flush_ifid,
  output logic            branch_taken
);

  localparam int NOPS = 2;

  logic [RA_W-1:0] ex_src [NOPS];
  logic [RA_W-1:0] id_src [NOPS];
  logic [1:0]      ex_sel [NOPS];
  logic [1:0]      id_sel [NOPS];
  logic [NOPS-1:0] ex_mem_hit, ex_wb_hit, id_mem_hit, id_wb_hit;

  // Named internal events, observed by the bound checker.
  logic hit_load_use, hit_br_alu, hit_br_load, stall_any;

  assign ex_src[0] = idex_rs;
  assign ex_src[1] = idex_rt;
  assign id_src[0] = ifid_rs;
  assign id_src[1] = ifid_rt;

  for (genvar g = 0; g < NOPS; g++) begin : g_ops
    hz_fwd_pick #(.RA_W(RA_W), .MEM_LOAD_OK(1'b1)) u_ex_pick (
      .src_reg (ex_src[g]),
      .mem_rd  (exmem_rd),
      .mem_wr  (exmem_regwrite),
      .mem_ld  (exmem_memread),
      .wb_rd   (memwb_rd),
      .wb_wr   (memwb_regwrite),
      .sel     (ex_sel[g]),
      .mem_hit (ex_mem_hit[g]),
      .wb_hit  (ex_wb_hit[g])
    );
    hz_fwd_pick #(.RA_W(RA_W), .MEM_LOAD_OK(1'b0)) u_id_pick (
      .src_reg (id_src[g]),
      .mem_rd  (exmem_rd),
      .mem_wr  (exmem_regwrite),
      .mem_ld  (exmem_memread),
      .wb_rd   (memwb_rd),
      .wb_wr   (memwb_regwrite),
      .sel     (id_sel[g]),
      .mem_hit (id_mem_hit[g]),
      .wb_hit  (id_wb_hit[g])
    );
  end

  hz_stall_det #(.RA_W(RA_W)) u_stall (
    .ifid_rs       (ifid_rs),
    .ifid_rt       (ifid_rt),
    .ifid_rt_used  (ifid_rt_used),
    .ifid_branch   (ifid_branch),
    .idex_rd       (idex_rd),
    .idex_regwrite (idex_regwrite),
    .idex_memread  (idex_memread),
    .exmem_rd      (exmem_rd),
    .exmem_memread (exmem_memread),
    .hit_load_use  (hit_load_use),
    .hit_br_alu    (hit_br_alu),
    .hit_br_load   (hit_br_load)
  );

  assign stall_any    = hit_load_use | hit_br_alu | hit_br_load;
  assign stall_pc     = stall_any;
  assign stall_ifid   = stall_any;
  assign bubble_idex  = stall_any;
  assign branch_taken = ifid_branch && ifid_cmp_eq && !stall_any;
  assign flush_ifid   = branch_taken;

  assign fwd_ex_a = ex_sel[0];
  assign fwd_ex_b = ex_sel[1];
  assign fwd_id_a = id_sel[0];
  assign fwd_id_b = id_sel[1];

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [RA_W-1:0] idex_rs,
  input logic [RA_W-1:0] exmem_rd,
  input logic            exmem_regwrite,
  input logic [1:0]      fwd_ex_a,
  input logic [1:0]      fwd_ex_b,
  input logic [1:0]      fwd_id_a,
  input logic [1:0]      fwd_id_b,
  input logic            stall_pc,
  input logic            stall_ifid,
  input logic            bubble_idex,
  input logic            flush_ifid,
  input logic            branch_taken,
  input logic            hit_load_use,
  input logic            hit_br_alu,
  input logic            hit_br_load
);

  a_r4_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_ex_a != 2'b11) && (fwd_ex_b != 2'b11) && (fwd_id_a != 2'b11) && (fwd_id_b != 2'b11));

  a_r4_reg0_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rs == '0) |-> (fwd_ex_a == 2'b00));

  a_r3_mem_stage_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_regwrite && (exmem_rd != '0) && (exmem_rd == idex_rs)) |-> (fwd_ex_a == 2'b10));

  a_r5_load_use_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    hit_load_use |-> (stall_pc && stall_ifid && bubble_idex));

  a_r6_branch_alu_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    hit_br_alu |-> (stall_pc && bubble_idex));

  a_r7_branch_load_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    hit_br_load |-> (stall_ifid && bubble_idex));

  a_r9_no_redirect_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall_pc |-> (!flush_ifid && !branch_taken));

  a_r10_stall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_load_use && !hit_br_alu && !hit_br_load) |-> (!stall_pc && !stall_ifid && !bubble_idex));

endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.RA_W(RA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .idex_rs        (idex_rs),
  .exmem_rd       (exmem_rd),
  .exmem_regwrite (exmem_regwrite),
  .fwd_ex_a       (fwd_ex_a),
  .fwd_ex_b       (fwd_ex_b),
  .fwd_id_a       (fwd_id_a),
  .fwd_id_b       (fwd_id_b),
  .stall_pc       (stall_pc),
  .stall_ifid     (stall_ifid),
  .bubble_idex    (bubble_idex),
  .flush_ifid     (flush_ifid),
  .branch_taken   (branch_taken),
  .hit_load_use   (hit_load_use),
  .hit_br_alu     (hit_br_alu),
  .hit_br_load    (hit_br_load)
);

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;

  localparam int RA_W = 5;

  typedef struct packed {
    logic [3:0] req;
    logic br, eq, rtu;
    logic [4:0] frs, frt, xrs, xrt, xrd;
    logic xwr, xld;
    logic [4:0] mrd;
    logic mwr, mld;
    logic [4:0] wrd;
    logic wwr;
    logic [1:0] efa, efb, eia, eib;
    logic est, efl;
  } vec_t;

  localparam int NV = 18;
  // Fields: req, br,eq,rtu, frs,frt, xrs,xrt,xrd, xwr,xld, mrd,mwr,mld, wrd,wwr, efa,efb,eia,eib, est,efl
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b0,1'b0,1'b0, 5'd0,5'd0,   5'd3,5'd4,5'd0,  1'b0,1'b0, 5'd3,1'b1,1'b0,  5'd0,1'b0,  2'b10,2'b00,2'b00,2'b00, 1'b0,1'b0}, // R1 operand A
    '{4'd1,  1'b0,1'b0,1'b0, 5'd0,5'd0,   5'd3,5'd4,5'd0,  1'b0,1'b0, 5'd4,1'b1,1'b0,  5'd0,1'b0,  2'b00,2'b10,2'b00,2'b00, 1'b0,1'b0}, // R1 operand B
    '{4'd2,  1'b0,1'b0,1'b0, 5'd0,5'd0,   5'd5,5'd9,5'd0,  1'b0,1'b0, 5'd0,1'b0,1'b0,  5'd5,1'b1,  2'b01,2'b00,2'b00,2'b00, 1'b0,1'b0}, // R2
    '{4'd3,  1'b0,1'b0,1'b0, 5'd0,5'd0,   5'd6,5'd6,5'd0,  1'b0,1'b0, 5'd6,1'b1,1'b0,  5'd6,1'b1,  2'b10,2'b10,2'b00,2'b00, 1'b0,1'b0}, // R3 both match
    '{4'd3,  1'b0,1'b0,1'b0, 5'd0,5'd0,   5'd6,5'd7,5'd0,  1'b0,1'b0, 5'd6,1'b1,1'b0,  5'd7,1'b1,  2'b10,2'b01,2'b00,2'b00, 1'b0,1'b0}, // R3 per operand
    '{4'd4,  1'b0,1'b0,1'b0, 5'd0,5'd0,   5'd0,5'd0,5'd0,  1'b0,1'b0, 5'd0,1'b1,1'b0,  5'd0,1'b1,  2'b00,2'b00,2'b00,2'b00, 1'b0,1'b0}, // R4 reg 0
    '{4'd4,  1'b0,1'b0,1'b0, 5'd0,5'd0,   5'd7,5'd7,5'd0,  1'b0,1'b0, 5'd7,1'b0,1'b0,  5'd7,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b0,1'b0}, // R4 no write
    '{4'd5,  1'b0,1'b0,1'b0, 5'd8,5'd0,   5'd0,5'd0,5'd8,  1'b1,1'b1, 5'd0,1'b0,1'b0,  5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b1,1'b0}, // R5 rs
    '{4'd5,  1'b0,1'b0,1'b1, 5'd0,5'd9,   5'd0,5'd0,5'd9,  1'b1,1'b1, 5'd0,1'b0,1'b0,  5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b1,1'b0}, // R5 rt used
    '{4'd5,  1'b0,1'b0,1'b0, 5'd0,5'd9,   5'd0,5'd0,5'd9,  1'b1,1'b1, 5'd0,1'b0,1'b0,  5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b0,1'b0}, // R5 rt unused
    '{4'd6,  1'b1,1'b1,1'b0, 5'd10,5'd0,  5'd0,5'd0,5'd10, 1'b1,1'b0, 5'd0,1'b0,1'b0,  5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b1,1'b0}, // R6
    '{4'd7,  1'b1,1'b1,1'b0, 5'd0,5'd11,  5'd0,5'd0,5'd0,  1'b0,1'b0, 5'd11,1'b1,1'b1, 5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b1,1'b0}, // R7
    '{4'd8,  1'b1,1'b0,1'b0, 5'd12,5'd0,  5'd0,5'd0,5'd0,  1'b0,1'b0, 5'd12,1'b1,1'b0, 5'd0,1'b0,  2'b00,2'b00,2'b10,2'b00, 1'b0,1'b0}, // R8 mem stage
    '{4'd8,  1'b1,1'b1,1'b0, 5'd0,5'd13,  5'd0,5'd0,5'd0,  1'b0,1'b0, 5'd0,1'b0,1'b0,  5'd13,1'b1, 2'b00,2'b00,2'b00,2'b01, 1'b0,1'b1}, // R8 write-back
    '{4'd8,  1'b1,1'b0,1'b0, 5'd14,5'd0,  5'd0,5'd0,5'd0,  1'b0,1'b0, 5'd14,1'b1,1'b0, 5'd14,1'b1, 2'b00,2'b00,2'b10,2'b00, 1'b0,1'b0}, // R8 priority
    '{4'd9,  1'b0,1'b1,1'b0, 5'd1,5'd2,   5'd0,5'd0,5'd0,  1'b0,1'b0, 5'd0,1'b0,1'b0,  5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b0,1'b0}, // R9 not a branch
    '{4'd10, 1'b0,1'b0,1'b0, 5'd15,5'd0,  5'd0,5'd0,5'd0,  1'b0,1'b0, 5'd15,1'b1,1'b1, 5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b0,1'b0}, // R10 load in mem
    '{4'd10, 1'b0,1'b0,1'b0, 5'd16,5'd0,  5'd0,5'd0,5'd16, 1'b1,1'b0, 5'd0,1'b0,1'b0,  5'd0,1'b0,  2'b00,2'b00,2'b00,2'b00, 1'b0,1'b0}  // R10 alu in ex
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RA_W-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd;
  logic ifid_rt_used, ifid_branch, ifid_cmp_eq, idex_regwrite, idex_memread;
  logic exmem_regwrite, exmem_memread, memwb_regwrite;
  logic [1:0] fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b;
  logic stall_pc, stall_ifid, bubble_idex, flush_ifid, branch_taken;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_hazard_ctl #(.RA_W(RA_W)) dut (.*);

  task automatic drive(input vec_t v);
    @(negedge clk);
    ifid_branch = v.br;   ifid_cmp_eq = v.eq;   ifid_rt_used = v.rtu;
    ifid_rs = v.frs;      ifid_rt = v.frt;
    idex_rs = v.xrs;      idex_rt = v.xrt;      idex_rd = v.xrd;
    idex_regwrite = v.xwr; idex_memread = v.xld;
    exmem_rd = v.mrd;     exmem_regwrite = v.mwr; exmem_memread = v.mld;
    memwb_rd = v.wrd;     memwb_regwrite = v.wwr;
  endtask

  task automatic check(input vec_t v, input string tag);
    logic [12:0] got, exp;
    #2;
    got = {fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b, stall_pc, stall_ifid, bubble_idex,
           flush_ifid, branch_taken};
    exp = {v.efa, v.efb, v.eia, v.eib, v.est, v.est, v.est, v.efl, v.efl};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic vec_t blank(input logic [3:0] r);
    vec_t v;
    v = '0;
    v.req = r;
    return v;
  endfunction

  initial begin
    vec_t v;
    drive(blank(4'd10));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: idle pipeline gives no forwarding, stall or redirect
    check(blank(4'd10), "R10 idle after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check(VECS[i], $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R9: taken branch with no hazard redirects and flushes
    v = blank(4'd9); v.br = 1'b1; v.eq = 1'b1; v.frs = 5'd1; v.frt = 5'd2; v.efl = 1'b1;
    drive(v); check(v, "R9 taken branch");

    // R5 then R7: load directly ahead of a branch on its rt, moved stage by stage
    v = blank(4'd5); v.br = 1'b1; v.eq = 1'b1; v.frt = 5'd20;
    v.xrd = 5'd20; v.xwr = 1'b1; v.xld = 1'b1; v.est = 1'b1;
    drive(v); check(v, "R5 branch behind load, first stall");
    v = blank(4'd7); v.br = 1'b1; v.eq = 1'b1; v.frt = 5'd20;
    v.mrd = 5'd20; v.mwr = 1'b1; v.mld = 1'b1; v.est = 1'b1;
    drive(v); check(v, "R7 branch behind load, second stall");
    v = blank(4'd8); v.br = 1'b1; v.eq = 1'b1; v.frt = 5'd20;
    v.wrd = 5'd20; v.wwr = 1'b1; v.eib = 2'b01; v.efl = 1'b1;
    drive(v); check(v, "R8 branch resolves with write-back forward");

    drive(blank(4'd10));
    check(blank(4'd10), "R10 idle at end");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule